// File: doc/BRIEF.md
# Ethernet MAC Pause Flow Control

This block sits in the transmit path of an Ethernet MAC and handles 802.3x pause flow control in both directions. On the sending side, a one-cycle request pulse, when sending is enabled, queues one minimum-size MAC control frame. The frame carries the programmed pause quanta. It goes out between data frames, ahead of any waiting data frame, and it goes out even while the transmitter is itself paused.

On the receiving side, the receive parser hands over a decoded quanta value with a strobe. When obeying is enabled, that value loads a pause timer. The timer counts down in slots of 512 bit times, and the length of a slot in clock cycles follows the selected link speed. While the timer is nonzero, no new data frame may start. A frame that is already on the wire runs to its end.

The data path is one byte per clock. Bytes on the transmit output are accepted every cycle. The upstream data source is paced by a ready signal.

Top module: `mac_pause_ctrl`

## Requirements
- R1: A control frame is exactly 60 bytes, flagged by `tx_ctrl`. Bytes 0-5 are 01 80 C2 00 00 01. Bytes 6-11 are `station_addr`, most significant byte first. Bytes 12-13 are 88 08 and bytes 14-15 are 00 01. Bytes 16-17 are `cfg_quanta`, high byte first, taken when the frame starts. Bytes 18-59 are zero.
- R2: A request sampled at clock edge k, with `cfg_send_en` high and the transmitter idle, puts control byte 0 on `tx_data` after edge k+1. Each request yields exactly one frame.
- R3: A request made while `cfg_send_en` is low produces no frame.
- R4: With `cfg_obey_en` high, a pause of Q quanta sampled at edge n holds `pause_active` high for exactly Q*L cycles, from after edge n through edge n+Q*L-1. L is QUANTUM_BITS/BITS_PER_CYCLE cycles at speed code 2 (1000 Mb/s), ten times that at code 1 (100 Mb/s) and a hundred times that at code 0 (10 Mb/s). Code 3 behaves as code 2.
- R5: A data frame already waiting while the pause runs starts with its first byte after edge n+Q*L+1.
- R6: A pause that arrives during a data frame does not interrupt that frame. Its bytes stay contiguous on the output.
- R7: A new received pause replaces the remaining time, and the count restarts from the new value.
- R8: A received quanta of zero clears `pause_active` at the next edge, so a waiting frame can start right away.
- R9: With `cfg_obey_en` low, received pauses do not raise `pause_active` and do not delay data frames.
- R10: A pending control frame goes ahead of a waiting data frame. It starts two edges after the data frame in progress ends, and it is also sent while `pause_active` is high.
- R11: After reset, `tx_valid`, `dat_ready` and `pause_active` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_speed | input | 2 | Link speed code: 0 = 10, 1 = 100, 2 or 3 = 1000 Mb/s |
| cfg_quanta | input | 16 | Quanta placed in sent control frames |
| cfg_send_en | input | 1 | Allows control frames to be sent |
| cfg_obey_en | input | 1 | Makes received pauses gate data frames |
| cfg_pause_req | input | 1 | One-cycle pulse requesting one control frame |
| station_addr | input | 48 | Source address of sent control frames |
| rx_pause_valid | input | 1 | Strobe: decoded received pause quanta valid |
| rx_pause_quanta | input | 16 | Received pause quanta |
| dat_valid | input | 1 | Data source byte valid |
| dat_data | input | 8 | Data source byte |
| dat_last | input | 1 | Marks the last byte of a data frame |
| dat_ready | output | 1 | Data byte taken on this edge |
| tx_valid | output | 1 | Output byte valid |
| tx_data | output | 8 | Output byte |
| tx_last | output | 1 | Last byte of the output frame |
| tx_ctrl | output | 1 | Output frame is a control frame |
| pause_active | output | 1 | Pause timer is nonzero |

## Verification
Each result has a fixed due cycle, counted in clock edges from the edge that sampled the stimulus. Control byte 0 appears one edge after the request edge. A received pause holds `pause_active` high through edge n+Q*L-1 and drops it at edge n+Q*L. A waiting data frame starts one edge after that, and after a zero-quanta cancel it starts at once. The bench keeps a running edge counter and samples outputs on the falling clock edge. A monitor stamps the starting and ending edge of every frame, so each check compares those stamps with the due edge worked out from Q, the slot length of the speed and the registers on the path.

// File: rtl/mac_pause_pkg.sv
package mac_pause_pkg;

   typedef enum logic [1:0] {
      TXS_IDLE = 2'd0,
      TXS_CTRL = 2'd1,
      TXS_DATA = 2'd2
   } txs_e;

   localparam logic [47:0] CTRL_DEST   = 48'h0180_C200_0001;
   localparam logic [15:0] CTRL_ETYPE  = 16'h8808;
   localparam logic [15:0] CTRL_OPCODE = 16'h0001;

   // Byte idx of a control frame. Fields are sent most significant byte first.
   function automatic logic [7:0] ctrl_byte(input int idx, input logic [47:0] sa,
                                            input logic [15:0] q);
      logic [7:0] b;
      if (idx < 6)        b = CTRL_DEST[8*(5-idx) +: 8];
      else if (idx < 12)  b = sa[8*(11-idx) +: 8];
      else if (idx == 12) b = CTRL_ETYPE[15:8];
      else if (idx == 13) b = CTRL_ETYPE[7:0];
      else if (idx == 14) b = CTRL_OPCODE[15:8];
      else if (idx == 15) b = CTRL_OPCODE[7:0];
      else if (idx == 16) b = q[15:8];
      else if (idx == 17) b = q[7:0];
      else                b = 8'h00;
      return b;
   endfunction

endpackage

// File: rtl/mac_pause_timer.sv
module mac_pause_timer #(
   parameter int QUANTUM_BITS   = 512,
   parameter int BITS_PER_CYCLE = 8,
   parameter int QW             = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [1:0]    speed,
   input  logic          obey_en,
   input  logic          rx_valid,
   input  logic [QW-1:0] rx_quanta,
   output logic          active
);
   localparam int BASE   = QUANTUM_BITS / BITS_PER_CYCLE;
   localparam int SW     = $clog2(BASE * 100 + 1);
   localparam int NSPEED = 4;

   if (QUANTUM_BITS % BITS_PER_CYCLE != 0) begin : g_bad_ratio
      $error("QUANTUM_BITS must be a multiple of BITS_PER_CYCLE");
   end
   if (BASE < 2) begin : g_bad_base
      $error("a quantum must span at least two cycles");
   end

   // Slot length in cycles for each speed code; codes 2 and 3 share the fastest rate.
   logic [SW-1:0] slot_tbl [NSPEED];
   for (genvar g = 0; g < NSPEED; g++) begin : g_speed
      localparam int DIV = (g == 0) ? 100 : ((g == 1) ? 10 : 1);
      assign slot_tbl[g] = SW'(BASE * DIV);
   end

   logic [SW-1:0] slot_len;
   logic [SW-1:0] slot;
   logic [QW-1:0] cnt;

   assign slot_len = slot_tbl[speed];
   assign active   = (cnt != '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt  <= '0;
         slot <= '0;
      end else if (!obey_en) begin
         cnt  <= '0;
         slot <= '0;
      end else if (rx_valid) begin
         cnt  <= rx_quanta;
         slot <= '0;
      end else if (cnt != '0) begin
         if (slot >= slot_len - 1'b1) begin
            slot <= '0;
            cnt  <= cnt - 1'b1;
         end else begin
            slot <= slot + 1'b1;
         end
      end
   end

   assert_zero_cancel_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (obey_en && rx_valid && rx_quanta == '0) |=> !active);
   assert_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (obey_en && rx_valid) |=> (cnt == $past(rx_quanta)));
   assert_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !obey_en |=> !active);
   assert_no_growth_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !rx_valid) |=> (cnt <= $past(cnt)));
endmodule

// File: rtl/mac_pause_framer.sv
module mac_pause_framer
   import mac_pause_pkg::*;
#(
   parameter int FRAME_BYTES = 60
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start,
   input  logic [47:0] src_addr,
   input  logic [15:0] quanta,
   output logic        busy,
   output logic [7:0]  data,
   output logic        last
);
   localparam int IW = $clog2(FRAME_BYTES);

   if (FRAME_BYTES < 18) begin : g_bad_len
      $error("FRAME_BYTES must hold the header and quanta");
   end

   logic [IW-1:0] idx;
   logic [15:0]   q_hold;

   assign last = busy && (idx == IW'(FRAME_BYTES - 1));
   assign data = busy ? ctrl_byte(int'(idx), src_addr, q_hold) : 8'h00;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         idx    <= '0;
         q_hold <= '0;
      end else if (start) begin
         busy   <= 1'b1;
         idx    <= '0;
         q_hold <= quanta;
      end else if (busy) begin
         if (last) begin
            busy <= 1'b0;
            idx  <= '0;
         end else begin
            idx <= idx + 1'b1;
         end
      end
   end

   assert_single_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !start);
   assert_quanta_held_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !start) |=> $stable(q_hold));
endmodule

// File: rtl/mac_pause_txgate.sv
module mac_pause_txgate
   import mac_pause_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   input  logic send_en,
   input  logic pause_active,
   input  logic dat_valid,
   input  logic dat_last,
   input  logic fr_last,
   output logic start_ctrl,
   output logic in_ctrl,
   output logic in_data
);
   txs_e state, state_nx;
   logic pend;

   assign start_ctrl = (state == TXS_IDLE) && pend;
   assign in_ctrl    = (state == TXS_CTRL);
   assign in_data    = (state == TXS_DATA);

   always_comb begin
      state_nx = state;
      unique case (state)
         TXS_IDLE: begin
            if (pend)                           state_nx = TXS_CTRL;
            else if (dat_valid && !pause_active) state_nx = TXS_DATA;
         end
         TXS_CTRL: if (fr_last)               state_nx = TXS_IDLE;
         TXS_DATA: if (dat_valid && dat_last) state_nx = TXS_IDLE;
         default:                             state_nx = TXS_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= TXS_IDLE;
         pend  <= 1'b0;
      end else begin
         state <= state_nx;
         if (req && send_en) pend <= 1'b1;
         else if (start_ctrl) pend <= 1'b0;
      end
   end

   assert_gated_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(in_data) |-> $past(!pause_active));
   assert_frame_whole_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_data && !(dat_valid && dat_last)) |=> in_data);
   assert_req_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!pend && !(req && send_en)) |=> !pend);
   assert_ctrl_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ((state == TXS_IDLE) && pend) |=> in_ctrl);
endmodule

// File: rtl/mac_pause_ctrl.sv
module mac_pause_ctrl
   import mac_pause_pkg::*;
#(
   parameter int QUANTUM_BITS   = 512,
   parameter int BITS_PER_CYCLE = 8,
   parameter int QUANTA_W       = 16,
   parameter int FRAME_BYTES    = 60
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [1:0]  cfg_speed,
   input  logic [15:0] cfg_quanta,
   input  logic        cfg_send_en,
   input  logic        cfg_obey_en,
   input  logic        cfg_pause_req,
   input  logic [47:0] station_addr,
   input  logic        rx_pause_valid,
   input  logic [15:0] rx_pause_quanta,
   input  logic        dat_valid,
   input  logic [7:0]  dat_data,
   input  logic        dat_last,
   output logic        dat_ready,
   output logic        tx_valid,
   output logic [7:0]  tx_data,
   output logic        tx_last,
   output logic        tx_ctrl,
   output logic        pause_active
);
   if (QUANTA_W != 16) begin : g_bad_qw
      $error("the pause quanta field is 16 bits wide");
   end

   logic       start_ctrl, in_ctrl, in_data;
   logic       fr_busy, fr_last;
   logic [7:0] fr_data;

   mac_pause_timer #(
      .QUANTUM_BITS  (QUANTUM_BITS),
      .BITS_PER_CYCLE(BITS_PER_CYCLE),
      .QW            (QUANTA_W)
   ) timer_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .speed    (cfg_speed),
      .obey_en  (cfg_obey_en),
      .rx_valid (rx_pause_valid),
      .rx_quanta(rx_pause_quanta),
      .active   (pause_active)
   );

   mac_pause_framer #(.FRAME_BYTES(FRAME_BYTES)) framer_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start_ctrl),
      .src_addr(station_addr),
      .quanta  (cfg_quanta),
      .busy    (fr_busy),
      .data    (fr_data),
      .last    (fr_last)
   );

   mac_pause_txgate gate_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .req         (cfg_pause_req),
      .send_en     (cfg_send_en),
      .pause_active(pause_active),
      .dat_valid   (dat_valid),
      .dat_last    (dat_last),
      .fr_last     (fr_last),
      .start_ctrl  (start_ctrl),
      .in_ctrl     (in_ctrl),
      .in_data     (in_data)
   );

   assign dat_ready = in_data;
   assign tx_ctrl   = in_ctrl;
   assign tx_valid  = in_ctrl ? fr_busy : (in_data && dat_valid);
   assign tx_data   = in_ctrl ? fr_data : (in_data ? dat_data : 8'h00);
   assign tx_last   = in_ctrl ? fr_last : (in_data && dat_valid && dat_last);

   assert_ctrl_contiguous_R1: assert property (@(posedge clk) disable iff (!rst_n)
      in_ctrl |-> tx_valid);
   assert_no_overlap_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(in_ctrl && dat_ready));
endmodule

// File: tb/mac_pause_ctrl_tb_top.sv
module mac_pause_ctrl_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int QB         = 64;
   localparam int BPC        = 8;
   localparam int BASE       = QB / BPC;
   localparam int LIMIT      = 150000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  cfg_speed = 2'd2;
   logic [15:0] cfg_quanta = 16'h0;
   logic        cfg_send_en = 1'b0, cfg_obey_en = 1'b0, cfg_pause_req = 1'b0;
   logic [47:0] station_addr = 48'h1234_5678_9ABC;
   logic        rx_pause_valid = 1'b0;
   logic [15:0] rx_pause_quanta = 16'h0;
   logic        dat_valid = 1'b0, dat_last = 1'b0;
   logic [7:0]  dat_data = 8'h0;
   logic        dat_ready, tx_valid, tx_last, tx_ctrl, pause_active;
   logic [7:0]  tx_data;

   mac_pause_ctrl #(.QUANTUM_BITS(QB), .BITS_PER_CYCLE(BPC)) dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_speed(cfg_speed), .cfg_quanta(cfg_quanta),
      .cfg_send_en(cfg_send_en), .cfg_obey_en(cfg_obey_en), .cfg_pause_req(cfg_pause_req),
      .station_addr(station_addr), .rx_pause_valid(rx_pause_valid),
      .rx_pause_quanta(rx_pause_quanta), .dat_valid(dat_valid), .dat_data(dat_data),
      .dat_last(dat_last), .dat_ready(dat_ready), .tx_valid(tx_valid), .tx_data(tx_data),
      .tx_last(tx_last), .tx_ctrl(tx_ctrl), .pause_active(pause_active));

   always #(CLK_PERIOD/2) clk = ~clk;

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int checks = 0, errors = 0;
   bit done = 0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   // frame monitor
   int         nrec = 0;
   bit         rec_ctrl [64];
   bit         rec_ok   [64];
   int         rec_start[64], rec_end[64], rec_len[64];
   logic [7:0] cbuf [64];
   int         cur_len = 0, cur_start = 0;
   bit         cur_ok = 1;
   logic [7:0] first_b = 8'h0;

   always @(negedge clk) begin
      if (rst_n && tx_valid) begin
         if (cur_len == 0) begin
            cur_start = cyc;
            first_b   = tx_data;
            cur_ok    = 1;
         end
         if (tx_ctrl && cur_len < 64) cbuf[cur_len] = tx_data;
         if (!tx_ctrl && tx_data != 8'(first_b + cur_len)) cur_ok = 0;
         cur_len++;
         if (tx_last) begin
            if (nrec < 64) begin
               rec_ctrl[nrec]  = tx_ctrl;
               rec_ok[nrec]    = cur_ok;
               rec_start[nrec] = cur_start;
               rec_end[nrec]   = cyc;
               rec_len[nrec]   = cur_len;
            end
            nrec++;
            cur_len = 0;
         end
      end
   end

   function automatic int slot_of(input int sp);
      return BASE * ((sp == 0) ? 100 : ((sp == 1) ? 10 : 1));
   endfunction

   function automatic logic [7:0] exp_ctrl(input int i, input logic [15:0] q);
      logic [7:0] hdr [16];
      hdr = '{8'h01, 8'h80, 8'hC2, 8'h00, 8'h00, 8'h01,
              8'h12, 8'h34, 8'h56, 8'h78, 8'h9A, 8'hBC,
              8'h88, 8'h08, 8'h00, 8'h01};
      if (i < 16) return hdr[i];
      if (i == 16) return q[15:8];
      if (i == 17) return q[7:0];
      return 8'h00;
   endfunction

   task automatic pulse_req(output int k);
      @(negedge clk) cfg_pause_req = 1'b1;
      @(posedge clk) k = cyc + 1;
      @(negedge clk) cfg_pause_req = 1'b0;
   endtask

   task automatic rx_pause(input logic [15:0] q, output int n);
      @(negedge clk);
      rx_pause_valid = 1'b1;
      rx_pause_quanta = q;
      @(posedge clk) n = cyc + 1;
      @(negedge clk) rx_pause_valid = 1'b0;
   endtask

   // Called at a falling edge; returns at the falling edge after the last byte is taken.
   task automatic send_frame(input int len, input logic [7:0] base);
      int  i = 0;
      bit  r;
      dat_valid = 1'b1;
      while (i < len) begin
         dat_data = 8'(base + i);
         dat_last = (i == len - 1);
         r = dat_ready;
         @(negedge clk);
         if (r) i++;
      end
      dat_valid = 1'b0;
      dat_last  = 1'b0;
   endtask

   task automatic wait_rec(input int target);
      int t = 0;
      while (nrec < target && t < 5000) begin
         @(negedge clk);
         t++;
      end
   endtask

   initial begin
      int k, n, n2, base_rec, t0, bad;
      repeat (3) @(negedge clk);
      // R11 reset state
      chk(tx_valid == 0, "R11 tx_valid", int'(tx_valid), 0);
      chk(dat_ready == 0, "R11 dat_ready", int'(dat_ready), 0);
      chk(pause_active == 0, "R11 pause_active", int'(pause_active), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R1 / R2 control frame format and timing
      cfg_send_en = 1'b1;
      cfg_quanta  = 16'h0100;
      base_rec = nrec;
      pulse_req(k);
      wait_rec(base_rec + 1);
      chk(rec_ctrl[base_rec] == 1, "R1 ctrl flag", int'(rec_ctrl[base_rec]), 1);
      chk(rec_len[base_rec] == 60, "R1 length", rec_len[base_rec], 60);
      chk(rec_start[base_rec] == k + 1, "R2 start edge", rec_start[base_rec], k + 1);
      bad = 0;
      for (int i = 0; i < 60; i++)
         if (cbuf[i] != exp_ctrl(i, 16'h0100)) begin
            bad++;
            $display("FAIL R1 byte %0d actual %0h expected %0h", i, cbuf[i], exp_ctrl(i, 16'h0100));
         end
      chk(bad == 0, "R1 content mismatches", bad, 0);
      repeat (100) @(negedge clk);
      chk(nrec == base_rec + 1, "R2 exactly one frame", nrec - base_rec, 1);

      // quanta taken at start, different value
      cfg_quanta = 16'hA55A;
      base_rec = nrec;
      pulse_req(k);
      wait_rec(base_rec + 1);
      chk(cbuf[16] == 8'hA5 && cbuf[17] == 8'h5A, "R1 quanta bytes",
          int'({cbuf[16], cbuf[17]}), 16'hA55A);

      // R3 disabled sending
      cfg_send_en = 1'b0;
      base_rec = nrec;
      pulse_req(k);
      repeat (100) @(negedge clk);
      chk(nrec == base_rec, "R3 no frame when disabled", nrec - base_rec, 0);

      // R4 / R5 sweep of speed codes and quanta
      cfg_obey_en = 1'b1;
      for (int sp = 0; sp < 4; sp++) begin
         for (int q = 1; q <= 3; q++) begin
            int L, due;
            L = slot_of(sp);
            cfg_speed = 2'(sp);
            base_rec = nrec;
            rx_pause(16'(q), n);
            due = n + q * L;
            chk(pause_active == 1, "R4 active after load", int'(pause_active), 1);
            fork
               send_frame(6, 8'(16 * q + sp));
               begin
                  while (cyc < due - 1) @(negedge clk);
                  chk(pause_active == 1, "R4 active last cycle", int'(pause_active), 1);
                  @(negedge clk);
                  chk(pause_active == 0, "R4 released", int'(pause_active), 0);
               end
            join
            wait_rec(base_rec + 1);
            chk(rec_start[base_rec] == due + 1, "R5 gated start", rec_start[base_rec], due + 1);
            chk(rec_len[base_rec] == 6 && rec_ok[base_rec], "R5 frame intact",
                rec_len[base_rec], 6);
         end
      end

      // R6 pause during a frame
      cfg_speed = 2'd1;
      base_rec = nrec;
      fork
         send_frame(20, 8'h40);
         begin
            repeat (6) @(negedge clk);
            rx_pause(16'd1, n);
         end
      join
      send_frame(10, 8'h80);
      wait_rec(base_rec + 2);
      chk(rec_len[base_rec] == 20 && rec_ok[base_rec], "R6 frame completes",
          rec_len[base_rec], 20);
      chk(rec_end[base_rec] - rec_start[base_rec] == 19, "R6 contiguous",
          rec_end[base_rec] - rec_start[base_rec], 19);
      chk(rec_start[base_rec + 1] == n + slot_of(1) + 1, "R6 next frame gated",
          rec_start[base_rec + 1], n + slot_of(1) + 1);

      // R7 overwrite
      cfg_speed = 2'd2;
      rx_pause(16'd3, n);
      repeat (10) @(negedge clk);
      rx_pause(16'd1, n2);
      while (cyc < n2 + BASE - 1) @(negedge clk);
      chk(pause_active == 1, "R7 reload active", int'(pause_active), 1);
      @(negedge clk);
      chk(pause_active == 0, "R7 reload expiry", int'(pause_active), 0);

      // R8 zero cancels
      rx_pause(16'd5, n);
      repeat (3) @(negedge clk);
      rx_pause(16'd0, n2);
      chk(pause_active == 0, "R8 cancelled", int'(pause_active), 0);
      base_rec = nrec;
      t0 = cyc;
      send_frame(4, 8'h10);
      wait_rec(base_rec + 1);
      chk(rec_start[base_rec] == t0 + 1, "R8 immediate start", rec_start[base_rec], t0 + 1);

      // R9 obey disabled
      cfg_obey_en = 1'b0;
      rx_pause(16'd3, n);
      chk(pause_active == 0, "R9 no pause", int'(pause_active), 0);
      base_rec = nrec;
      t0 = cyc;
      send_frame(4, 8'h20);
      wait_rec(base_rec + 1);
      chk(rec_start[base_rec] == t0 + 1, "R9 not delayed", rec_start[base_rec], t0 + 1);

      // R10 control frame sent during a pause, data waits
      cfg_obey_en = 1'b1;
      cfg_send_en = 1'b1;
      cfg_speed = 2'd1;
      base_rec = nrec;
      rx_pause(16'd2, n);
      fork
         send_frame(5, 8'h30);
         begin
            repeat (3) @(negedge clk);
            pulse_req(k);
         end
      join
      wait_rec(base_rec + 2);
      chk(rec_ctrl[base_rec] == 1, "R10 ctrl during pause", int'(rec_ctrl[base_rec]), 1);
      chk(rec_start[base_rec] == k + 1, "R10 ctrl start in pause", rec_start[base_rec], k + 1);
      chk(rec_start[base_rec + 1] == n + 2 * slot_of(1) + 1, "R10 data after pause",
          rec_start[base_rec + 1], n + 2 * slot_of(1) + 1);

      // R10 ctrl ahead of a waiting data frame
      base_rec = nrec;
      fork
         begin
            send_frame(30, 8'h50);
            send_frame(5, 8'h90);
         end
         begin
            repeat (8) @(negedge clk);
            pulse_req(k);
         end
      join
      wait_rec(base_rec + 3);
      chk(rec_ctrl[base_rec + 1] == 1, "R10 ctrl before data", int'(rec_ctrl[base_rec + 1]), 1);
      chk(rec_start[base_rec + 1] == rec_end[base_rec] + 2, "R10 ctrl start",
          rec_start[base_rec + 1], rec_end[base_rec] + 2);
      chk(rec_ctrl[base_rec + 2] == 0 && rec_start[base_rec + 2] == rec_end[base_rec + 1] + 2,
          "R10 data after ctrl", rec_start[base_rec + 2], rec_end[base_rec + 1] + 2);

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   always @(posedge clk) begin
      if (!done && cyc > LIMIT) begin
         done = 1;
         checks++;
         errors++;
         $display("FAIL watchdog actual %0d expected %0d", cyc, LIMIT);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule